// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture

This block is a free-running up-counter with a programmable prescaler in front of it. The count source is either the system clock (timer mode) or the selected edges of an external count input (counter mode); the external input is synchronized into the system clock domain before its edges are detected. The prescaler divides the source events by (limit + 1), and the main counter advances once per prescaled event, which is called a tick below.

Four match slots compare the value the counter is about to take against their own compare value. When a tick brings the counter onto a compare value, the slot can:

- set an interrupt flag;
- stop the counter;
- drive its own output pin low, high, toggle it, or leave it unchanged.

A slot with reset enabled makes the tick after the match return the counter to zero, so the period is the compare value plus one.

Two capture channels take a snapshot of the counter when their synchronized input shows the selected edge, and they can also flag an interrupt. All flags are sticky and are cleared by write-one-to-clear. Software-style control reaches the block only through simple level and pulse ports: start, halt, load and the configuration inputs.

Top module: `evt_timer`

## Requirements
- R1: After reset, the following all read zero: `count`, `running`, `match_out`, `cap_val`, `irq_flags` and `irq`.
- R2: In timer mode (`count_mode`=0), while running, `count` rises by one on every (`presc_limit`+1)-th system clock cycle.
- R3: In counter mode (`count_mode`=1), each selected edge of `ext_clk` counts as one prescaler event. The edge selection `ext_edge_sel` is encoded 01 rising, 10 falling, 11 both and 00 none.
- R4: A match happens when a tick moves `count` onto the compare value of slot i. On a match, flag bit i is set only if `match_irq_en[i]` is 1. `irq` is the OR of all flag bits.
- R5: With `match_rst_en[i]` set, the tick that follows a match on slot i sets `count` to zero instead of compare+1.
- R6: With `match_stop_en[i]` set, a match on slot i clears `running`, and `count` holds the compare value.
- R7: On a match, `match_out[i]` follows the 2-bit field `match_out_mode[2i+1:2i]`: 00 unchanged, 01 driven low, 10 driven high, 11 toggled.
- R8: Capture channel j copies `count` into `cap_val[j*W +: W]` on the edge of `cap_in[j]` selected by `cap_edge_sel[2j+1:2j]` (01 rising, 10 falling, 11 both, 00 none). It sets flag bit N_MATCH+j if `cap_irq_en[j]` is 1.
- R9: Flags are sticky. A one on `irq_clr[k]` clears flag bit k and leaves the other bits untouched. A set in the same cycle wins over the clear.
- R10: A `cnt_load` pulse writes `cnt_load_val` into `count`, restarts the prescaler from zero, and raises no match event.
- R11: While `running` is 0, `count` holds. `run_halt` wins over `run_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Pulse: set the run state |
| run_halt | input | 1 | Pulse: clear the run state |
| count_mode | input | 1 | 0 timer, 1 external-edge counter |
| ext_clk | input | 1 | External count input (asynchronous) |
| ext_edge_sel | input | 2 | Edges of ext_clk that count |
| presc_limit | input | W | Prescaler terminal value |
| cnt_load | input | 1 | Pulse: load the counter |
| cnt_load_val | input | W | Value for cnt_load |
| match_val | input | N_MATCH*W | Compare values, slot i at [i*W +: W] |
| match_irq_en | input | N_MATCH | Per-slot flag enable |
| match_rst_en | input | N_MATCH | Per-slot reset-on-match |
| match_stop_en | input | N_MATCH | Per-slot stop-on-match |
| match_out_mode | input | 2*N_MATCH | Per-slot output action |
| cap_in | input | N_CAP | Capture inputs (asynchronous) |
| cap_edge_sel | input | 2*N_CAP | Per-channel capture edge |
| cap_irq_en | input | N_CAP | Per-channel flag enable |
| irq_clr | input | N_MATCH+N_CAP | Write-one-to-clear for flags |
| count | output | W | Counter value |
| running | output | 1 | Run state |
| match_out | output | N_MATCH | Match-driven output pins |
| cap_val | output | N_CAP*W | Captured values |
| irq_flags | output | N_MATCH+N_CAP | Sticky flags, matches low, captures high |
| irq | output | 1 | OR of all flags |

## Verification
The prescaled count is driven from a table of prescale values and run lengths. The table includes lengths that are not a multiple of the period, so an off-by-one in the terminal compare or in the start and halt boundary produces a wrong count. The external source is tried with rising-only, both-edge and falling-with-prescale patterns, which tells the three edge selections apart and shows whether the prescaler sits in the external path. The match tests place several slots on the same compare value, each with a different output action, and repeat the run with the opposite levels; this separates set, clear, toggle and no-action. Capture is driven with the counter halted at known loaded values, so a wrong edge choice shows up as a stale or unexpected snapshot.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    OUT_KEEP = 2'b00,
    OUT_LOW  = 2'b01,
    OUT_HIGH = 2'b10,
    OUT_FLIP = 2'b11
  } out_act_e;

  // sel[0] enables rising edges, sel[1] enables falling edges
  function automatic logic edge_hit(input logic [1:0] sel, input logic now, input logic prev);
    return (sel[0] & now & ~prev) | (sel[1] & ~now & prev);
  endfunction
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign hit = evt_timer_pkg::edge_hit(sel, chain[STAGES-1], prev);
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc;
  logic         at_lim;

  assign at_lim = (pc >= limit);
  assign tick   = advance & at_lim;

  always_ff @(posedge clk) begin
    if (rst || clear)  pc <= '0;
    else if (advance)  pc <= at_lim ? '0 : pc + 1'b1;
  end
endmodule

// File: rtl/evt_match_slot.sv
module evt_match_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] mval,
  input  logic [1:0]   mode,
  output logic         hit,
  output logic         out
);
  import evt_timer_pkg::*;

  assign hit = tick & (nxt == mval);

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else if (hit) begin
      case (out_act_e'(mode))
        OUT_LOW:  out <= 1'b0;
        OUT_HIGH: out <= 1'b1;
        OUT_FLIP: out <= ~out;
        default:  out <= out;
      endcase
    end
  end
endmodule

// File: rtl/evt_capture_slot.sv
module evt_capture_slot #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  input  logic [1:0]   sel,
  input  logic [W-1:0] count,
  output logic         hit,
  output logic [W-1:0] val
);
  evt_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(din), .sel(sel), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (hit) val <= count;
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W           = 32,
  parameter int N_MATCH     = 4,
  parameter int N_CAP       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_start,
  input  logic                     run_halt,
  input  logic                     count_mode,
  input  logic                     ext_clk,
  input  logic [1:0]               ext_edge_sel,
  input  logic [W-1:0]             presc_limit,
  input  logic                     cnt_load,
  input  logic [W-1:0]             cnt_load_val,
  input  logic [N_MATCH*W-1:0]     match_val,
  input  logic [N_MATCH-1:0]       match_irq_en,
  input  logic [N_MATCH-1:0]       match_rst_en,
  input  logic [N_MATCH-1:0]       match_stop_en,
  input  logic [2*N_MATCH-1:0]     match_out_mode,
  input  logic [N_CAP-1:0]         cap_in,
  input  logic [2*N_CAP-1:0]       cap_edge_sel,
  input  logic [N_CAP-1:0]         cap_irq_en,
  input  logic [N_MATCH+N_CAP-1:0] irq_clr,
  output logic [W-1:0]             count,
  output logic                     running,
  output logic [N_MATCH-1:0]       match_out,
  output logic [N_CAP*W-1:0]       cap_val,
  output logic [N_MATCH+N_CAP-1:0] irq_flags,
  output logic                     irq
);
  localparam int N_FLAG = N_MATCH + N_CAP;

  logic [W-1:0]       cnt_q, cnt_nxt;
  logic               run_q, ext_hit, src_evt, adv, tick;
  logic [N_MATCH-1:0] at_match, m_hit;
  logic [N_CAP-1:0]   c_hit;
  logic [N_FLAG-1:0]  flag_q, flag_set, flag_nxt;

  // count source: every cycle or synchronized external edges
  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .din(ext_clk), .sel(ext_edge_sel), .hit(ext_hit)
  );

  assign src_evt = count_mode ? ext_hit : 1'b1;
  assign adv     = run_q & src_evt & ~cnt_load;

  evt_prescaler #(.W(W)) u_pre (
    .clk(clk), .rst(rst), .clear(cnt_load), .advance(adv),
    .limit(presc_limit), .tick(tick)
  );

  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    assign at_match[i] = (cnt_q == match_val[i*W +: W]);
    evt_match_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .tick(tick), .nxt(cnt_nxt),
      .mval(match_val[i*W +: W]), .mode(match_out_mode[2*i +: 2]),
      .hit(m_hit[i]), .out(match_out[i])
    );
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    evt_capture_slot #(.W(W), .STAGES(SYNC_STAGES)) u_slot (
      .clk(clk), .rst(rst), .din(cap_in[j]), .sel(cap_edge_sel[2*j +: 2]),
      .count(cnt_q), .hit(c_hit[j]), .val(cap_val[j*W +: W])
    );
  end

  // reset-on-match takes effect on the tick after the match
  assign cnt_nxt = (|(at_match & match_rst_en)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (cnt_load) cnt_q <= cnt_load_val;
    else if (tick)     cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                          run_q <= 1'b0;
    else if (run_halt)                run_q <= 1'b0;
    else if (|(m_hit & match_stop_en)) run_q <= 1'b0;
    else if (run_start)               run_q <= 1'b1;
  end

  assign flag_set = {c_hit & cap_irq_en, m_hit & match_irq_en};
  assign flag_nxt = (flag_q & ~irq_clr) | flag_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq    <= |flag_nxt;
    end
  end

  assign count     = cnt_q;
  assign running   = run_q;
  assign irq_flags = flag_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W       = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     run_halt,
  input logic                     cnt_load,
  input logic [W-1:0]             cnt_load_val,
  input logic [N_MATCH*W-1:0]     match_val,
  input logic [N_MATCH-1:0]       match_stop_en,
  input logic [N_MATCH+N_CAP-1:0] irq_clr,
  input logic [W-1:0]             count,
  input logic                     running,
  input logic [N_MATCH+N_CAP-1:0] irq_flags
);
  logic [N_MATCH-1:0] on_stop;
  for (genvar i = 0; i < N_MATCH; i++) begin : g_eq
    assign on_stop[i] = match_stop_en[i] & (count == match_val[i*W +: W]);
  end

  // R11: idle counter holds
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!running && !cnt_load) |=> $stable(count));

  // R2: a running counter steps by at most one or wraps to zero
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (running && !cnt_load) |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  // R10: load value appears one cycle later
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> (count == $past(cnt_load_val)));

  // R6: run state drops only on halt or on a stop slot holding the count
  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(run_halt) || (|on_stop)));

  // R9: uncleared flags stay set
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (|(irq_flags & ~irq_clr)) |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));
endmodule

bind evt_timer evt_timer_chk #(.W(W), .N_MATCH(N_MATCH), .N_CAP(N_CAP)) u_chk (
  .clk(clk), .rst(rst), .run_halt(run_halt), .cnt_load(cnt_load),
  .cnt_load_val(cnt_load_val), .match_val(match_val), .match_stop_en(match_stop_en),
  .irq_clr(irq_clr), .count(count), .running(running), .irq_flags(irq_flags)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
  localparam int W = 32, NM = 4, NC = 2, NF = NM + NC;

  logic clk = 1'b0, rst = 1'b1;
  logic run_start = 0, run_halt = 0, count_mode = 0, ext_clk = 0, cnt_load = 0;
  logic [1:0] ext_edge_sel = 2'b01;
  logic [W-1:0] presc_limit = '0, cnt_load_val = '0;
  logic [NM*W-1:0] match_val = {NM{32'hFFFF_0000}};
  logic [NM-1:0] match_irq_en = '0, match_rst_en = '0, match_stop_en = '0;
  logic [2*NM-1:0] match_out_mode = '0;
  logic [NC-1:0] cap_in = '0, cap_irq_en = '0;
  logic [2*NC-1:0] cap_edge_sel = '0;
  logic [NF-1:0] irq_clr = '0;
  logic [W-1:0] count;
  logic running, irq;
  logic [NM-1:0] match_out;
  logic [NC*W-1:0] cap_val;
  logic [NF-1:0] irq_flags;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  evt_timer dut (
    .clk(clk), .rst(rst), .run_start(run_start), .run_halt(run_halt),
    .count_mode(count_mode), .ext_clk(ext_clk), .ext_edge_sel(ext_edge_sel),
    .presc_limit(presc_limit), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .match_val(match_val), .match_irq_en(match_irq_en), .match_rst_en(match_rst_en),
    .match_stop_en(match_stop_en), .match_out_mode(match_out_mode), .cap_in(cap_in),
    .cap_edge_sel(cap_edge_sel), .cap_irq_en(cap_irq_en), .irq_clr(irq_clr),
    .count(count), .running(running), .match_out(match_out), .cap_val(cap_val),
    .irq_flags(irq_flags), .irq(irq)
  );

  typedef struct packed { logic [31:0] presc; logic [31:0] cyc; logic [31:0] exp; } vec_t;
  localparam vec_t VEC [5] = '{
    '{32'd0, 32'd9,  32'd10},
    '{32'd1, 32'd9,  32'd5},
    '{32'd2, 32'd10, 32'd3},
    '{32'd3, 32'd6,  32'd1},
    '{32'd4, 32'd3,  32'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic start_run();
    run_start = 1; @(negedge clk); run_start = 0;
  endtask
  task automatic halt_run();
    run_halt = 1; @(negedge clk); run_halt = 0;
  endtask
  task automatic load_cnt(input logic [W-1:0] v);
    cnt_load_val = v; cnt_load = 1; @(negedge clk); cnt_load = 0;
  endtask
  task automatic ext_pulses(input int n);
    for (int p = 0; p < n; p++) begin
      ext_clk = 1; wait_n(4); ext_clk = 0; wait_n(4);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [W-1:0] hold, mx;
    logic saw_wrap;
    wait_n(3); rst = 0; wait_n(1);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 running", running, 0);
    check("R1 match_out", match_out, 0);
    check("R1 cap_val", cap_val, 0);
    check("R1 flags", {irq, irq_flags}, 0);

    // R2 / R11 table of prescale and run lengths
    for (int k = 0; k < 5; k++) begin
      presc_limit = VEC[k].presc;
      load_cnt(0);
      start_run();
      wait_n(VEC[k].cyc);
      halt_run();
      check($sformatf("R2 vec%0d count", k), count, VEC[k].exp);
      hold = count;
      wait_n(5);
      check($sformatf("R11 vec%0d hold", k), count, hold);
    end

    // R11 halt wins over start
    run_start = 1; run_halt = 1; @(negedge clk); run_start = 0; run_halt = 0;
    check("R11 halt wins", running, 0);

    // R3 counter mode
    count_mode = 1; presc_limit = 0; ext_edge_sel = 2'b01;
    load_cnt(0); start_run(); ext_pulses(5); wait_n(5);
    check("R3 rising", count, 5);
    ext_edge_sel = 2'b11; load_cnt(0); ext_pulses(3); wait_n(5);
    check("R3 both", count, 6);
    ext_edge_sel = 2'b10; presc_limit = 1; load_cnt(0); ext_pulses(4); wait_n(5);
    check("R3 falling prescaled", count, 2);
    halt_run(); count_mode = 0; presc_limit = 0;

    // R10 load restarts prescaler
    presc_limit = 3; load_cnt(0); start_run(); wait_n(1);
    load_cnt(100); wait_n(3);
    check("R10 prescaler restart before tick", count, 100);
    wait_n(1);
    check("R10 prescaler restart tick", count, 101);
    halt_run(); presc_limit = 0;

    // R4 / R5 irq and reset on match
    match_val[0 +: W] = 3; match_rst_en = 4'b0001; match_irq_en = 4'b0001;
    load_cnt(0); start_run();
    mx = 0; saw_wrap = 0;
    for (int c = 0; c < 12; c++) begin
      wait_n(1);
      if (count > mx) mx = count;
      if (mx == 3 && count == 0) saw_wrap = 1;
    end
    halt_run();
    check("R5 max count", mx, 3);
    check("R5 wrap to zero", saw_wrap, 1);
    check("R4 flags", irq_flags, 6'b000001);
    check("R4 irq", irq, 1);

    // R9 clear
    irq_clr = 6'b000001; @(negedge clk); irq_clr = 0;
    check("R9 cleared flags", irq_flags, 0);
    check("R9 irq low", irq, 0);

    // R6 stop on match, R4 no flag without enable
    match_rst_en = 0; match_irq_en = 0; match_val[0 +: W] = 32'hFFFF_0000;
    match_val[W +: W] = 5; match_stop_en = 4'b0010;
    load_cnt(0); start_run(); wait_n(15);
    check("R6 running", running, 0);
    check("R6 count", count, 5);
    check("R4 no flag without enable", irq_flags, 0);

    // R7 output actions
    check("R7 outputs idle", match_out, 0);
    match_val = {32'd4, 32'd2, 32'd2, 32'd2};
    match_stop_en = 4'b1000;
    match_out_mode = 8'b10_00_11_10;
    load_cnt(0); start_run(); wait_n(10);
    check("R7 run1 count", count, 4);
    check("R7 run1 outputs", match_out, 4'b1011);
    match_out_mode = 8'b01_00_11_01;
    load_cnt(0); start_run(); wait_n(10);
    check("R7 run2 outputs", match_out, 4'b0000);

    // R10 load onto a compare value raises nothing
    match_val[0 +: W] = 7; match_irq_en = 4'b0001; match_stop_en = 0;
    load_cnt(7); wait_n(2);
    check("R10 load count", count, 7);
    check("R10 load no flag", irq_flags, 0);
    match_irq_en = 0;

    // R8 capture
    cap_edge_sel = 4'b10_01; cap_irq_en = 2'b01;
    load_cnt(32'h55); cap_in = 2'b11; wait_n(5);
    check("R8 ch0 rise", cap_val[0 +: W], 32'h55);
    check("R8 ch1 no rise", cap_val[W +: W], 0);
    check("R8 flags", irq_flags, 6'b010000);
    load_cnt(32'h66); cap_in = 2'b00; wait_n(5);
    check("R8 ch0 no fall", cap_val[0 +: W], 32'h55);
    check("R8 ch1 fall", cap_val[W +: W], 32'h66);
    check("R8 ch1 no flag", irq_flags, 6'b010000);
    cap_edge_sel = 4'b10_11;
    load_cnt(32'h77); cap_in = 2'b01; wait_n(5);
    check("R8 both rise", cap_val[0 +: W], 32'h77);
    load_cnt(32'h88); cap_in = 2'b00; wait_n(5);
    check("R8 both fall", cap_val[0 +: W], 32'h88);

    // R9 partial clear
    irq_clr = 6'b100000; @(negedge clk); irq_clr = 0;
    check("R9 other bit kept", irq_flags, 6'b010000);
    irq_clr = 6'b010000; @(negedge clk); irq_clr = 0;
    check("R9 bit cleared", irq_flags, 0);

    // R1 mid-run reset
    match_val = {NM{32'd1}}; match_out_mode = 8'b10_10_10_10; cap_irq_en = 2'b11;
    load_cnt(0); start_run(); cap_in = 2'b01; wait_n(6);
    check("R7 all high", match_out, 4'hF);
    rst = 1; wait_n(2); rst = 0; cap_in = 0; wait_n(1);
    check("R1 reset count", count, 0);
    check("R1 reset running", running, 0);
    check("R1 reset outputs", match_out, 0);
    check("R1 reset caps/flags", {cap_val, irq_flags, irq}, 0);
    summary();
  end
endmodule